// File: doc/BRIEF.md
# Lease-Timestamp L2 Bank Controller

This block is one bank of a shared second-level cache in a GPU. It keeps the bank coherent with the first-level caches by using time alone: each line carries an expiry time, and a first-level copy may be used only until that time has passed. A load names how long it wants to hold its copy. The bank grants the lease, returns the expiry time and pushes the line's expiry time forward if it needs to. A store is never held back while leases are live. It updates the line and returns the global time by which every first-level copy of that line will have lapsed, so that the writer can order later work behind it. No invalidation, recall or acknowledgement traffic exists at all.

The bank is direct-mapped with one data word per line. A store writes through to a simple backing store. A load miss reads the word from the backing store over a fixed number of cycles and is then serviced. Requests arrive over a valid/ready port with at most one accepted per cycle. Responses come back in acceptance order. A free-running 32-bit global time is an input.

Top module: `lts_l2_bank`

## Requirements
- R1: After reset every line is invalid with expiry time 0, `req_ready_o` is 1, and `rsp_valid_o`, `mem_rd_o` and `mem_wr_o` are 0.
- R2: A load that hits (the slot selected by the low `log2(DEPTH)` address bits is valid and holds the same address) is answered in the cycle after acceptance with `rsp_store_o`=0, the line's data, and `rsp_time_o` equal to the global time in the acceptance cycle plus the requested lifetime.
- R3: A load sets the line's expiry time to the larger of its old value and the newly granted expiry, so a shorter lease never shortens an earlier one; this shows in the completion time of a later store.
- R4: A store is answered in the cycle after acceptance with `rsp_store_o`=1, whether it hits or misses and whatever the line's lease. `rsp_time_o` is the line's expiry time if that is later than the global time in the acceptance cycle, and that global time otherwise. The line then holds the store's address and data.
- R5: In the cycle after a store is accepted, `mem_wr_o` is 1 with the store's address on `mem_addr_o` and its data on `mem_wdata_o`. `mem_wr_o` and `mem_rd_o` are never 1 together.
- R6: A load miss holds `mem_rd_o` at 1 with the load's address for `FILL_LAT` cycles, beginning the cycle after acceptance, and samples `mem_rdata_i` in the last of them. The response follows in the next cycle with that data and `rsp_time_o` equal to the global time of that last cycle plus the requested lifetime.
- R7: A slot that is reallocated to a new address by a store or a fill keeps its expiry time (raised as R3 says for a load), so a store to the new address still waits out leases granted on the old one.
- R8: `req_ready_o` is 0 exactly while a fill is in progress. Otherwise one request is accepted per cycle, and each accepted request gets exactly one response, in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gtime_i | input | 32 | Free-running global time |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | AW | Word address |
| req_life_i | input | LW | Requested lease length for a load |
| req_wdata_i | input | DW | Store data |
| rsp_valid_o | output | 1 | Response valid (one cycle) |
| rsp_store_o | output | 1 | Response belongs to a store |
| rsp_data_o | output | DW | Load data (store data echoed for stores) |
| rsp_time_o | output | 32 | Granted expiry (load) or write completion time (store) |
| mem_rd_o | output | 1 | Backing-store read in progress |
| mem_wr_o | output | 1 | Backing-store write strobe |
| mem_addr_o | output | AW | Backing-store address |
| mem_wdata_o | output | DW | Backing-store write data |
| mem_rdata_i | input | DW | Backing-store read data for `mem_addr_o` |

## Verification
Two things can meet on the same line in one cycle: the response to a load that has just extended a lease goes out while a store to that line is being accepted, and that store must see the extended expiry when it forms its completion time. The bench provokes this by sending a load and a store to one address back to back, both after a hit and right after a fill. It also sends a store to an address that collides with a live lease on a different address. A behavioural model tracks every slot's expiry and judges each response's time against it on every clock.

// File: rtl/lts_pkg.sv
package lts_pkg;
    typedef logic [31:0] gtime_t;

    // later of two global times
    function automatic gtime_t later_of(gtime_t a, gtime_t b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/lts_lease_calc.sv
module lts_lease_calc
    import lts_pkg::*;
#(
    parameter int LW = 16
) (
    input  gtime_t          now_i,
    input  logic [LW-1:0]   life_i,
    input  gtime_t          line_ts_i,
    output gtime_t          grant_o,
    output gtime_t          ts_ext_o,
    output gtime_t          gwct_o
);
    localparam int PADW = 32 - LW;

    always_comb begin
        grant_o  = now_i + {{PADW{1'b0}}, life_i};
        ts_ext_o = later_of(line_ts_i, grant_o);
        // equal to now means lapsed: now is returned either way
        gwct_o   = later_of(line_ts_i, now_i);
    end
endmodule

// File: rtl/lts_fill_timer.sv
module lts_fill_timer #(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic last_o
);
    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = run_i ? CW'(cnt_q + 1'b1) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = run_i && (cnt_q == CW'(LAT - 1));
endmodule

// File: rtl/lts_l2_bank.sv
module lts_l2_bank
    import lts_pkg::*;
#(
    parameter int AW       = 12,
    parameter int DW       = 32,
    parameter int LW       = 16,
    parameter int DEPTH    = 16,
    parameter int FILL_LAT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [31:0]   gtime_i,
    input  logic          req_valid_i,
    output logic          req_ready_o,
    input  logic          req_store_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [LW-1:0] req_life_i,
    input  logic [DW-1:0] req_wdata_i,
    output logic          rsp_valid_o,
    output logic          rsp_store_o,
    output logic [DW-1:0] rsp_data_o,
    output logic [31:0]   rsp_time_o,
    output logic          mem_rd_o,
    output logic          mem_wr_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i
);
    localparam int IW = $clog2(DEPTH);
    localparam int TW = AW - IW;

    typedef struct {
        logic          vld  [DEPTH];
        logic [TW-1:0] tag  [DEPTH];
        logic [DW-1:0] data [DEPTH];
        gtime_t        ts   [DEPTH];
        logic          busy;
        logic [AW-1:0] p_addr;
        logic [LW-1:0] p_life;
        logic          rsp_v;
        logic          rsp_st;
        logic [DW-1:0] rsp_data;
        gtime_t        rsp_time;
        logic          mem_wr;
        logic [AW-1:0] mem_addr;
        logic [DW-1:0] mem_wdata;
    } bank_t;

    bank_t st_d, st_q;

    logic          fill_last;
    logic          accept;
    logic          hit;
    logic [IW-1:0] req_idx, sel_idx;
    logic [TW-1:0] req_tag, sel_tag;
    logic [LW-1:0] sel_life;
    gtime_t        grant, ts_ext, gwct;

    assign req_idx  = req_addr_i[IW-1:0];
    assign req_tag  = req_addr_i[AW-1:IW];
    assign sel_idx  = st_q.busy ? st_q.p_addr[IW-1:0]  : req_idx;
    assign sel_tag  = st_q.busy ? st_q.p_addr[AW-1:IW] : req_tag;
    assign sel_life = st_q.busy ? st_q.p_life : req_life_i;
    assign accept   = req_valid_i && !st_q.busy;
    assign hit      = st_q.vld[req_idx] && (st_q.tag[req_idx] == req_tag);

    lts_fill_timer #(.LAT(FILL_LAT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (st_q.busy),
        .last_o (fill_last)
    );

    lts_lease_calc #(.LW(LW)) u_calc (
        .now_i     (gtime_i),
        .life_i    (sel_life),
        .line_ts_i (st_q.ts[sel_idx]),
        .grant_o   (grant),
        .ts_ext_o  (ts_ext),
        .gwct_o    (gwct)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rsp_v  = 1'b0;
        st_d.mem_wr = 1'b0;
        if (st_q.busy) begin
            if (fill_last) begin
                st_d.vld[sel_idx]  = 1'b1;
                st_d.tag[sel_idx]  = sel_tag;
                st_d.data[sel_idx] = mem_rdata_i;
                st_d.ts[sel_idx]   = ts_ext;
                st_d.rsp_v         = 1'b1;
                st_d.rsp_st        = 1'b0;
                st_d.rsp_data      = mem_rdata_i;
                st_d.rsp_time      = grant;
                st_d.busy          = 1'b0;
            end
        end else if (accept) begin
            st_d.mem_addr = req_addr_i;
            if (req_store_i) begin
                st_d.vld[req_idx]  = 1'b1;
                st_d.tag[req_idx]  = req_tag;
                st_d.data[req_idx] = req_wdata_i;
                st_d.rsp_v         = 1'b1;
                st_d.rsp_st        = 1'b1;
                st_d.rsp_data      = req_wdata_i;
                st_d.rsp_time      = gwct;
                st_d.mem_wr        = 1'b1;
                st_d.mem_wdata     = req_wdata_i;
            end else if (hit) begin
                st_d.ts[req_idx]   = ts_ext;
                st_d.rsp_v         = 1'b1;
                st_d.rsp_st        = 1'b0;
                st_d.rsp_data      = st_q.data[req_idx];
                st_d.rsp_time      = grant;
            end else begin
                st_d.busy   = 1'b1;
                st_d.p_addr = req_addr_i;
                st_d.p_life = req_life_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                st_q.vld[i]  <= 1'b0;
                st_q.tag[i]  <= '0;
                st_q.data[i] <= '0;
                st_q.ts[i]   <= '0;
            end
            st_q.busy      <= 1'b0;
            st_q.p_addr    <= '0;
            st_q.p_life    <= '0;
            st_q.rsp_v     <= 1'b0;
            st_q.rsp_st    <= 1'b0;
            st_q.rsp_data  <= '0;
            st_q.rsp_time  <= '0;
            st_q.mem_wr    <= 1'b0;
            st_q.mem_addr  <= '0;
            st_q.mem_wdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready_o = !st_q.busy;
    assign rsp_valid_o = st_q.rsp_v;
    assign rsp_store_o = st_q.rsp_st;
    assign rsp_data_o  = st_q.rsp_data;
    assign rsp_time_o  = st_q.rsp_time;
    assign mem_rd_o    = st_q.busy;
    assign mem_wr_o    = st_q.mem_wr;
    assign mem_addr_o  = st_q.mem_addr;
    assign mem_wdata_o = st_q.mem_wdata;
endmodule

// File: rtl/lts_l2_bank_chk.sv
module lts_l2_bank_chk #(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [31:0]   gtime_i,
    input logic          req_valid_i,
    input logic          req_ready_o,
    input logic          req_store_i,
    input logic [AW-1:0] req_addr_i,
    input logic [DW-1:0] req_wdata_i,
    input logic          rsp_valid_o,
    input logic          rsp_store_o,
    input logic [31:0]   rsp_time_o,
    input logic          mem_rd_o,
    input logic          mem_wr_o,
    input logic [AW-1:0] mem_addr_o,
    input logic [DW-1:0] mem_wdata_o
);
    logic st_acc, ld_acc;
    assign st_acc = req_valid_i && req_ready_o && req_store_i;
    assign ld_acc = req_valid_i && req_ready_o && !req_store_i;

    p_store_answered_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_acc |=> (rsp_valid_o && rsp_store_o));

    p_gwct_not_before_now_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_store_o) |-> (rsp_time_o >= $past(gtime_i)));

    p_grant_not_before_now_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && !rsp_store_o) |-> (rsp_time_o >= $past(gtime_i)));

    p_write_through_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_acc |=> (mem_wr_o && mem_addr_o == $past(req_addr_i)
                    && mem_wdata_o == $past(req_wdata_i)));

    p_port_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));

    p_fill_from_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_o) |-> $past(ld_acc));

    p_fill_addr_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && $past(mem_rd_o)) |-> $stable(mem_addr_o));

    p_fill_answered_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_rd_o) |-> (rsp_valid_o && !rsp_store_o));
endmodule

bind lts_l2_bank lts_l2_bank_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .gtime_i     (gtime_i),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_store_i (req_store_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_store_o (rsp_store_o),
    .rsp_time_o  (rsp_time_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
);

// File: tb/tb_lts_l2_bank.sv
module tb_lts_l2_bank;
    localparam int AW = 8, DW = 32, LW = 12, DEPTH = 8, LAT = 3;
    localparam int IW = $clog2(DEPTH);
    localparam int MW = 1 << AW;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic [31:0]   gtime_i;
    logic          req_valid_i, req_ready_o, req_store_i;
    logic [AW-1:0] req_addr_i;
    logic [LW-1:0] req_life_i;
    logic [DW-1:0] req_wdata_i;
    logic          rsp_valid_o, rsp_store_o;
    logic [DW-1:0] rsp_data_o;
    logic [31:0]   rsp_time_o;
    logic          mem_rd_o, mem_wr_o;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_wdata_o, mem_rdata_i;

    lts_l2_bank #(.AW(AW), .DW(DW), .LW(LW), .DEPTH(DEPTH), .FILL_LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .gtime_i(gtime_i),
        .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_store_i(req_store_i),
        .req_addr_i(req_addr_i), .req_life_i(req_life_i), .req_wdata_i(req_wdata_i),
        .rsp_valid_o(rsp_valid_o), .rsp_store_o(rsp_store_o), .rsp_data_o(rsp_data_o),
        .rsp_time_o(rsp_time_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
    );

    // backing store driven by the DUT's own port
    logic [DW-1:0] bmem [MW];
    always @(posedge clk) if (mem_wr_o) bmem[mem_addr_o] <= mem_wdata_o;
    assign mem_rdata_i = bmem[mem_addr_o];

    // behavioural reference
    bit            m_vld  [DEPTH];
    logic [AW-1:0] m_addr [DEPTH];
    logic [DW-1:0] m_data [DEPTH];
    logic [31:0]   m_ts   [DEPTH];
    logic [DW-1:0] m_mem  [MW];
    bit            m_busy;
    int            m_cnt;
    logic [AW-1:0] p_addr;
    logic [LW-1:0] p_life;

    bit            e_rv, e_rs, e_rd, e_wr, e_ready;
    logic [DW-1:0] e_rdata, e_wdata;
    logic [31:0]   e_rtime;
    logic [AW-1:0] e_addr;
    string         e_req;

    int    n_chk = 0, n_fail = 0;
    string scen = "R1";
    logic [31:0] gt = 32'd100;
    int    gstep = 1;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s [%s] %s act=%0h exp=%0h", req, scen, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("R8", "req_ready", 32'(req_ready_o), 32'(e_ready));
        chk("R8", "rsp_valid", 32'(rsp_valid_o), 32'(e_rv));
        if (e_rv) begin
            chk(e_req, "rsp_store", 32'(rsp_store_o), 32'(e_rs));
            chk(e_req, "rsp_time", rsp_time_o, e_rtime);
            if (!e_rs) chk(e_req, "rsp_data", rsp_data_o, e_rdata);
        end
        chk("R6", "mem_rd", 32'(mem_rd_o), 32'(e_rd));
        chk("R5", "mem_wr", 32'(mem_wr_o), 32'(e_wr));
        if (e_rd || e_wr) chk(e_rd ? "R6" : "R5", "mem_addr", 32'(mem_addr_o), 32'(e_addr));
        if (e_wr) chk("R5", "mem_wdata", mem_wdata_o, e_wdata);
    endtask

    task automatic cycle(bit v, bit st, logic [AW-1:0] a, logic [LW-1:0] life,
                         logic [DW-1:0] d, output bit acc);
        logic [31:0] g;
        int i;
        @(negedge clk);
        compare();
        req_valid_i = v; req_store_i = st; req_addr_i = a;
        req_life_i = life; req_wdata_i = d; gtime_i = gt;
        e_rv = 0; e_wr = 0; acc = 0;
        if (m_busy) begin
            if (m_cnt == LAT - 1) begin
                i = int'(p_addr) % DEPTH;
                g = gt + 32'(p_life);
                m_vld[i] = 1; m_addr[i] = p_addr; m_data[i] = m_mem[p_addr];
                if (g > m_ts[i]) m_ts[i] = g;
                e_rv = 1; e_rs = 0; e_rdata = m_data[i]; e_rtime = g; e_req = "R6";
                m_busy = 0;
            end else m_cnt++;
        end else if (v) begin
            acc = 1;
            i = int'(a) % DEPTH;
            e_addr = a;
            if (st) begin
                e_rv = 1; e_rs = 1; e_req = "R4";
                e_rtime = (m_ts[i] > gt) ? m_ts[i] : gt;
                m_vld[i] = 1; m_addr[i] = a; m_data[i] = d; m_mem[a] = d;
                e_wr = 1; e_wdata = d;
            end else if (m_vld[i] && m_addr[i] == a) begin
                g = gt + 32'(life);
                if (g > m_ts[i]) m_ts[i] = g;
                e_rv = 1; e_rs = 0; e_rdata = m_data[i]; e_rtime = g; e_req = "R2";
            end else begin
                m_busy = 1; m_cnt = 0; p_addr = a; p_life = life;
            end
        end
        e_rd = m_busy;
        e_ready = !m_busy;
        @(posedge clk);
        gt = gt + 32'(gstep);
    endtask

    task automatic send(bit st, logic [AW-1:0] a, int life, logic [DW-1:0] d);
        bit acc = 0;
        while (!acc) cycle(1'b1, st, a, LW'(life), d, acc);
    endtask

    task automatic idle(int n);
        bit acc;
        for (int k = 0; k < n; k++) cycle(1'b0, 1'b0, '0, '0, '0, acc);
    endtask

    initial begin
        #(4 * 60000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < MW; k++) begin
            bmem[k] = 32'hA000_0000 + 32'(k * 7);
            m_mem[k] = 32'hA000_0000 + 32'(k * 7);
        end
        for (int k = 0; k < DEPTH; k++) begin
            m_vld[k] = 0; m_addr[k] = '0; m_data[k] = '0; m_ts[k] = '0;
        end
        m_busy = 0; m_cnt = 0; p_addr = '0; p_life = '0;
        e_rv = 0; e_rs = 0; e_rd = 0; e_wr = 0; e_ready = 1;
        e_rdata = '0; e_wdata = '0; e_rtime = '0; e_addr = '0; e_req = "R1";
        rst_n = 0; req_valid_i = 0; req_store_i = 0; req_addr_i = '0;
        req_life_i = '0; req_wdata_i = '0; gtime_i = gt;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1: idle outputs straight after reset
        scen = "R1";
        idle(2);

        // R6: cold miss fill, then R2: hit with a shorter lease (R3 keeps the longer one)
        scen = "R6"; send(0, 8'h05, 40, '0); idle(LAT + 1);
        scen = "R2"; send(0, 8'h05, 3, '0); idle(1);
        // R3: store right after a short-lease hit sees the longer expiry
        scen = "R3"; send(0, 8'h05, 2, '0); send(1, 8'h05, 0, 32'h1111_2222); idle(2);
        // R4: store after the lease has lapsed returns current time
        scen = "R4"; gt = gt + 200; send(1, 8'h05, 0, 32'h3333_4444); idle(1);
        send(0, 8'h05, 7, '0); idle(1);
        // R6: global time moves during the fill; grant uses the last fill cycle
        scen = "R6"; gstep = 5; send(0, 8'h16, 20, '0); send(1, 8'h16, 0, 32'h5555); gstep = 1; idle(2);
        // R7: conflicting store inherits the live lease of the evicted line
        scen = "R7"; send(0, 8'h03, 0, '0); idle(LAT + 1);
        send(0, 8'h03, 90, '0); send(1, 8'h13, 0, 32'h7777); idle(1);
        send(0, 8'h23, 1, '0); idle(LAT + 1); send(1, 8'h23, 0, 32'h8888); idle(2);
        // R8: back-to-back mixed stream, hit responses overlapping next acceptance
        scen = "R8";
        send(1, 8'h01, 0, 32'h1); send(1, 8'h02, 0, 32'h2); send(0, 8'h01, 4, '0);
        send(0, 8'h02, 5, '0); send(0, 8'h42, 6, '0); send(1, 8'h42, 0, 32'h9); idle(LAT + 2);

        // mixed random traffic over a few colliding addresses
        scen = "R8";
        for (int n = 0; n < 400; n++) begin
            logic [AW-1:0] a;
            a = AW'({$urandom_range(0, 2), 3'(($urandom_range(0, 3)))});
            gstep = $urandom_range(0, 3);
            if ($urandom_range(0, 15) == 0) gt = gt + 32'($urandom_range(0, 60));
            if ($urandom_range(0, 4) == 0) idle(1);
            else send($urandom_range(0, 2) == 0, a, $urandom_range(0, 50), $urandom);
        end
        gstep = 1;
        idle(LAT + 3);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule